// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers interrupt sources into two first-level groups of eight lines each. Each group drives one CPU interrupt line. A third set of eight shared sources reaches the first level through a cascade. Two independent mask registers filter that shared set. The OR of the first filtered set takes bit 7 of group 0. The OR of the second filtered set takes bit 3 of group 1. Each shared source can therefore be routed to either CPU line, to both, or to neither.

Software reaches the block over a simple word-addressed register bus. Reads are combinational and return 32 bits. Writes take effect at the clock edge and carry 8 bits. Two edge-triggered timer latches are also included. A write to a dedicated clear register drops them, and their state can be read back at the same word.

Top module: `cascade_intc`

## Requirements
- R1: After reset, every mask register reads 0, both CPU interrupt lines are low and both timer latches are clear.
- R2: Word 0 returns the group-0 status. Bits 6:0 are the raw levels of `src_l0[6:0]`. Bit 7 is the OR of (`src_map` AND map-mask-0), and the pin `src_l0[7]` is not used.
- R3: Word 2 returns the group-1 status. Bits 7:4 and 2:0 are the raw levels of `src_l1`. Bit 3 is the OR of (`src_map` AND map-mask-1), and the pin `src_l1[3]` is not used.
- R4: Word 4 returns the raw levels of `src_map`, whatever the mask values.
- R5: The mask registers are at word 1 (group 0), word 3 (group 1), word 5 (map mask 0) and word 6 (map mask 1). A write stores `bus_wdata`, and a read returns the stored value. Bits 31:8 of every read are zero.
- R6: `irq_out[0]` equals the OR of (group-0 status AND group-0 mask), registered, so it follows a change one clock edge later.
- R7: `irq_out[1]` equals the OR of (group-1 status AND group-1 mask), registered the same way.
- R8: The two map masks act independently on the same shared sources. A shared source reaches a CPU line only through the map mask of that line's group.
- R9: Writes to the status words (0, 2 and 4) leave every mask register unchanged.
- R10: Timer latch i sets on a rising edge of `tmr_pulse[i]`. It then stays set while the input stays high or falls. A level that stays high does not set the latch again after it has been cleared.
- R11: A write to word 7 clears timer latch i when `bus_wdata[i]` is 1 (a value of 0x03 clears both). A read of word 7 returns the latches in bits 1:0. If a rising edge and a clear of the same latch arrive in one cycle, the latch ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_l0 | input | 8 | Level sources of group 0 (bit 7 unused) |
| src_l1 | input | 8 | Level sources of group 1 (bit 3 unused) |
| src_map | input | 8 | Shared mappable level sources |
| tmr_pulse | input | 2 | Timer event inputs, rising-edge sensitive |
| bus_addr | input | 3 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_out | output | 2 | Registered CPU interrupt lines, one per group |
| tmr_irq | output | 2 | Timer latch state |

## Verification
Directed patterns come first. A lone source is tested with its mask off and then on, which separates masking from raw status. A shared source is routed through one map mask, then both, then neither, which shows whether the two cascade paths are independent. Driving the unused pins `src_l0[7]` and `src_l1[3]` shows that the cascade overrides the raw pin at those positions. Timer tests cover a held-high input after a clear and a clear that collides with an edge. Seeded random masks and sources then compare both status words and both interrupt lines against a bench model, which catches wrong bit positions and swapped masks.

// File: rtl/cic_pkg.sv
package cic_pkg;

    localparam int GRP_W     = 8;
    localparam int DATA_W    = 32;
    localparam int IDX_W     = 3;
    localparam int NUM_TMR   = 2;
    localparam int NUM_GRP   = 2;
    localparam int CASC_POS0 = 7;
    localparam int CASC_POS1 = 3;

    typedef enum logic [IDX_W-1:0] {
        W_L0_STAT  = 3'd0,
        W_L0_MASK  = 3'd1,
        W_L1_STAT  = 3'd2,
        W_L1_MASK  = 3'd3,
        W_MAP_STAT = 3'd4,
        W_MAP_MSK0 = 3'd5,
        W_MAP_MSK1 = 3'd6,
        W_TMR_CLR  = 3'd7
    } word_e;

    typedef struct packed {
        logic [GRP_W-1:0] grp0;
        logic [GRP_W-1:0] grp1;
        logic [GRP_W-1:0] map0;
        logic [GRP_W-1:0] map1;
    } mask_set_t;

    function automatic logic [DATA_W-1:0] widen(input logic [GRP_W-1:0] v);
        return {{(DATA_W-GRP_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/cic_mask_regs.sv
module cic_mask_regs
    import cic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  word_e            word,
    input  logic [GRP_W-1:0] wdata,
    output mask_set_t        masks
);
    always_ff @(posedge clk) begin
        if (rst) begin
            masks <= '0;
        end else if (wr_en) begin
            case (word)
                W_L0_MASK:  masks.grp0 <= wdata;
                W_L1_MASK:  masks.grp1 <= wdata;
                W_MAP_MSK0: masks.map0 <= wdata;
                W_MAP_MSK1: masks.map1 <= wdata;
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/cic_group.sv
module cic_group
    import cic_pkg::*;
#(
    parameter int CASC_POS = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [GRP_W-1:0] src,
    input  logic             casc,
    input  logic [GRP_W-1:0] mask,
    output logic [GRP_W-1:0] status,
    output logic             irq
);
    always_comb begin
        status           = src;
        status[CASC_POS] = casc;
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(status & mask);
    end
endmodule

// File: rtl/cic_tmr_latch.sv
module cic_tmr_latch (
    input  logic clk,
    input  logic rst,
    input  logic pulse,
    input  logic clr,
    output logic flag
);
    logic pulse_q;
    logic rise;

    assign rise = pulse & ~pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
            flag    <= 1'b0;
        end else begin
            pulse_q <= pulse;
            if (rise)     flag <= 1'b1;
            else if (clr) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/cascade_intc.sv
module cascade_intc
    import cic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [GRP_W-1:0]   src_l0,
    input  logic [GRP_W-1:0]   src_l1,
    input  logic [GRP_W-1:0]   src_map,
    input  logic [NUM_TMR-1:0] tmr_pulse,
    input  logic [IDX_W-1:0]   bus_addr,
    input  logic               bus_wr,
    input  logic [GRP_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_GRP-1:0] irq_out,
    output logic [NUM_TMR-1:0] tmr_irq
);
    word_e            word;
    mask_set_t        masks;
    logic [GRP_W-1:0] stat0;
    logic [GRP_W-1:0] stat1;
    logic             casc0;
    logic             casc1;

    assign word  = word_e'(bus_addr);
    assign casc0 = |(src_map & masks.map0);
    assign casc1 = |(src_map & masks.map1);

    cic_mask_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr),
        .word  (word),
        .wdata (bus_wdata),
        .masks (masks)
    );

    cic_group #(.CASC_POS(CASC_POS0)) u_grp0 (
        .clk    (clk),
        .rst    (rst),
        .src    (src_l0),
        .casc   (casc0),
        .mask   (masks.grp0),
        .status (stat0),
        .irq    (irq_out[0])
    );

    cic_group #(.CASC_POS(CASC_POS1)) u_grp1 (
        .clk    (clk),
        .rst    (rst),
        .src    (src_l1),
        .casc   (casc1),
        .mask   (masks.grp1),
        .status (stat1),
        .irq    (irq_out[1])
    );

    generate
        for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
            cic_tmr_latch u_latch (
                .clk   (clk),
                .rst   (rst),
                .pulse (tmr_pulse[t]),
                .clr   (bus_wr && word == W_TMR_CLR && bus_wdata[t]),
                .flag  (tmr_irq[t])
            );
        end
    endgenerate

    always_comb begin
        case (word)
            W_L0_STAT:  bus_rdata = widen(stat0);
            W_L0_MASK:  bus_rdata = widen(masks.grp0);
            W_L1_STAT:  bus_rdata = widen(stat1);
            W_L1_MASK:  bus_rdata = widen(masks.grp1);
            W_MAP_STAT: bus_rdata = widen(src_map);
            W_MAP_MSK0: bus_rdata = widen(masks.map0);
            W_MAP_MSK1: bus_rdata = widen(masks.map1);
            default:    bus_rdata = {{(DATA_W-NUM_TMR){1'b0}}, tmr_irq};
        endcase
    end
endmodule

// File: rtl/cascade_intc_chk.sv
module cascade_intc_chk
    import cic_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [GRP_W-1:0]   src_l0,
    input logic [GRP_W-1:0]   src_l1,
    input logic [GRP_W-1:0]   src_map,
    input logic [NUM_TMR-1:0] tmr_pulse,
    input logic [IDX_W-1:0]   bus_addr,
    input logic               bus_wr,
    input logic [GRP_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_GRP-1:0] irq_out,
    input logic [NUM_TMR-1:0] tmr_irq,
    input mask_set_t          masks
);
    logic [GRP_W-1:0] m_st0;
    logic [GRP_W-1:0] m_st1;

    always_comb begin
        m_st0            = src_l0;
        m_st0[CASC_POS0] = |(src_map & masks.map0);
        m_st1            = src_l1;
        m_st1[CASC_POS1] = |(src_map & masks.map1);
    end

    // R6
    irq0_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> irq_out[0] == $past(|(m_st0 & masks.grp0)));

    // R7
    irq1_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> irq_out[1] == $past(|(m_st1 & masks.grp1)));

    // R4
    map_raw_chk: assert property (@(posedge clk) disable iff (rst)
        bus_addr == W_MAP_STAT |-> bus_rdata == widen(src_map));

    // R5
    mask_store_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_addr == W_MAP_MSK1 |=> masks.map1 == $past(bus_wdata));

    // R9
    stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr && (bus_addr == W_L0_STAT || bus_addr == W_L1_STAT ||
                   bus_addr == W_MAP_STAT) |=> $stable(masks));

    // R10
    tmr_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tmr_pulse[0]) |=> tmr_irq[0]);

    // R11
    tmr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$rose(tmr_pulse[1]) && bus_wr &&
        bus_addr == W_TMR_CLR && bus_wdata[1] |=> !tmr_irq[1]);

    // R2
    casc_pos_chk: assert property (@(posedge clk) disable iff (rst)
        bus_addr == W_L0_STAT |-> bus_rdata[CASC_POS0] == |(src_map & masks.map0));
endmodule

bind cascade_intc cascade_intc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_l0    (src_l0),
    .src_l1    (src_l1),
    .src_map   (src_map),
    .tmr_pulse (tmr_pulse),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .tmr_irq   (tmr_irq),
    .masks     (masks)
);

// File: tb/cascade_intc_tb.sv
module cascade_intc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SEED       = 1234;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  src_l0, src_l1, src_map;
    logic [1:0]  tmr_pulse;
    logic [2:0]  bus_addr;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_out;
    logic [1:0]  tmr_irq;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic [7:0] m_g0, m_g1, m_m0, m_m1;

    always #(CLK_PERIOD/2) clk = ~clk;

    cascade_intc u_dut (
        .clk(clk), .rst(rst), .src_l0(src_l0), .src_l1(src_l1),
        .src_map(src_map), .tmr_pulse(tmr_pulse), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .tmr_irq(tmr_irq)
    );

    function automatic logic [7:0] exp_st0(input logic [7:0] s, input logic [7:0] mp, input logic [7:0] mm);
        logic [7:0] r = s;
        r[7] = |(mp & mm);
        return r;
    endfunction

    function automatic logic [7:0] exp_st1(input logic [7:0] s, input logic [7:0] mp, input logic [7:0] mm);
        logic [7:0] r = s;
        r[3] = |(mp & mm);
        return r;
    endfunction

    function automatic logic [1:0] exp_irq();
        return {|(exp_st1(src_l1, src_map, m_m1) & m_g1),
                |(exp_st0(src_l0, src_map, m_m0) & m_g0)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            3'd1: m_g0 = d;
            3'd3: m_g1 = d;
            3'd5: m_m0 = d;
            3'd6: m_m1 = d;
            default: ;
        endcase
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic irq_chk(input string tag);
        @(negedge clk);
        chk(tag, {30'd0, irq_out}, {30'd0, exp_irq()});
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(SEED));
        rst = 1'b1; src_l0 = '0; src_l1 = '0; src_map = '0; tmr_pulse = '0;
        bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
        m_g0 = '0; m_g1 = '0; m_m0 = '0; m_m1 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        rd("R1 grp0 mask", 3'd1, 32'd0);
        rd("R1 grp1 mask", 3'd3, 32'd0);
        rd("R1 map mask0", 3'd5, 32'd0);
        rd("R1 map mask1", 3'd6, 32'd0);
        chk("R1 irq", {30'd0, irq_out}, 32'd0);
        chk("R1 timers", {30'd0, tmr_irq}, 32'd0);

        // R6 masked then unmasked source
        @(negedge clk); src_l0 = 8'h01;
        irq_chk("R6 masked src");
        chk("R6 masked src low", {31'd0, irq_out[0]}, 32'd0);
        wr(3'd1, 8'h01);
        irq_chk("R6 unmasked src");
        chk("R6 line high", {31'd0, irq_out[0]}, 32'd1);
        rd("R2 raw status", 3'd0, 32'h01);

        // R3 pin at cascade position unused; R7
        @(negedge clk); src_l0 = 8'h80; src_l1 = 8'h08;
        wr(3'd3, 8'h08);
        irq_chk("R7 cascade pin ignored");
        rd("R3 status bit3 from cascade", 3'd2, 32'h00);
        rd("R2 status bit7 from cascade", 3'd0, 32'h00);
        @(negedge clk); src_l1 = 8'h10;
        wr(3'd3, 8'h10);
        irq_chk("R7 group1 line");
        chk("R7 line high", {31'd0, irq_out[1]}, 32'd1);

        // R8 shared source routing
        @(negedge clk); src_l0 = 8'h00; src_l1 = 8'h00; src_map = 8'h20;
        wr(3'd1, 8'h80); wr(3'd3, 8'h08);
        wr(3'd5, 8'h20);
        irq_chk("R8 route to group0 only");
        chk("R8 group0 only", {30'd0, irq_out}, 32'd1);
        rd("R4 map raw", 3'd4, 32'h20);
        wr(3'd6, 8'h20);
        irq_chk("R8 route to both");
        chk("R8 both lines", {30'd0, irq_out}, 32'd3);
        wr(3'd5, 8'h00);
        irq_chk("R8 route to group1 only");
        chk("R8 group1 only", {30'd0, irq_out}, 32'd2);
        rd("R3 cascade bit", 3'd2, 32'h08);

        // R9 writes to status words
        wr(3'd0, 8'hff); wr(3'd2, 8'hff); wr(3'd4, 8'hff);
        rd("R9 grp0 mask kept", 3'd1, {24'd0, m_g0});
        rd("R9 grp1 mask kept", 3'd3, {24'd0, m_g1});
        rd("R9 map0 kept", 3'd5, {24'd0, m_m0});
        rd("R9 map1 kept", 3'd6, {24'd0, m_m1});

        // R10 / R11 timers
        @(negedge clk); tmr_pulse = 2'b01;
        @(negedge clk);
        chk("R10 latch set on edge", {30'd0, tmr_irq}, 32'd1);
        @(negedge clk); tmr_pulse = 2'b00;
        @(negedge clk);
        chk("R10 latch held after fall", {30'd0, tmr_irq}, 32'd1);
        rd("R11 latch readback", 3'd7, 32'd1);
        @(negedge clk); tmr_pulse = 2'b01;
        @(negedge clk);
        wr(3'd7, 8'h01);
        @(negedge clk);
        chk("R10 held level no reset", {30'd0, tmr_irq}, 32'd0);
        @(negedge clk); tmr_pulse = 2'b10;
        bus_addr = 3'd7; bus_wdata = 8'h02; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        chk("R11 edge beats clear", {30'd0, tmr_irq}, 32'd2);
        @(negedge clk); tmr_pulse = 2'b00;
        @(negedge clk); tmr_pulse = 2'b01;
        @(negedge clk); tmr_pulse = 2'b00;
        chk("R11 both set", {30'd0, tmr_irq}, 32'd3);
        wr(3'd7, 8'h03);
        chk("R11 clear both", {30'd0, tmr_irq}, 32'd0);

        // random mix: R2 R3 R5 R6 R7
        for (int i = 0; i < 60; i++) begin
            wr(3'd1, 8'($urandom)); wr(3'd3, 8'($urandom));
            wr(3'd5, 8'($urandom)); wr(3'd6, 8'($urandom));
            @(negedge clk);
            src_l0 = 8'($urandom); src_l1 = 8'($urandom);
            src_map = 8'($urandom & $urandom);
            irq_chk("R6 R7 random irq");
            rd("R2 random status", 3'd0, {24'd0, exp_st0(src_l0, src_map, m_m0)});
            rd("R3 random status", 3'd2, {24'd0, exp_st1(src_l1, src_map, m_m1)});
            rd("R5 random mask", 3'd6, {24'd0, m_m1});
        end

        done = 1;
        finish_run();
    end
endmodule